// File: doc/BRIEF.md
# Segmented Quartic Function Evaluator

This block approximates an arbitrary scalar function y = f(x) by splitting the argument range into 64 equal segments. Each segment has its own fourth-order polynomial, so the shape of the function is set entirely by a writable coefficient table and not by logic. A typical use is inside a pairwise-force datapath. There the argument is a scaled squared distance (separation squared plus a softening term, times a scale factor), and the result is then multiplied by the coordinate difference.

An unsigned fixed-point argument enters on a free-running stream with a valid flag and no backpressure. The upper bits choose the segment. The lower bits form a local offset dx in [0, 1). The polynomial is evaluated in Horner form by a chain of pipelined multiply-add stages. A result leaves a fixed number of cycles later with its own valid flag. Coefficients and results share one signed fixed-point scaling, which the user picks. A separate write port loads one coefficient per cycle while the pipeline keeps running.

Top module: `quartic_seg_eval`

## Requirements
- R1: While rst_ni is low and after its release, valid_o and y_o are 0 and every coefficient reads as 0, so the first evaluation after reset returns 0.
- R2: For an argument below 64*1024, the segment is arg_i[15:10] and the local offset is the unsigned value dx = arg_i[9:0], read as dx/1024.
- R3: With c_k the coefficient of dx^k, the result is acc = c4, then for k = 3, 2, 1, 0 in turn acc = ((acc*dx + 512) >>> 10) + c_k. This rounds each product to nearest, with ties toward plus infinity, and wraps to 20-bit two's complement.
- R4: Each argument taken with valid_i high gives exactly one result with valid_o high 6 clock edges later. Back-to-back arguments give back-to-back results, and cycles with valid_i low give no result.
- R5: An argument of 64*1024 or more is evaluated as segment 63 with dx = 1023, which is the same result as argument 0x0FFFF.
- R6: A write with wr_en_i high stores wr_data_i (signed 16-bit) as the coefficient of dx^wr_idx_i for segment wr_seg_i when wr_idx_i is 0 to 4. A write with wr_idx_i of 5, 6 or 7 changes nothing.
- R7: A write at the same clock edge that captures an argument, or at any later edge, does not change that argument's result. Arguments captured after the write edge use the new coefficient.
- R8: An argument with dx = 0 returns exactly that segment's c0, sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Argument valid |
| arg_i | input | 18 | Unsigned argument: segment in bits 15:10, offset in bits 9:0, bits 17:16 force saturation |
| wr_en_i | input | 1 | Coefficient write strobe |
| wr_seg_i | input | 6 | Segment to write |
| wr_idx_i | input | 3 | Power of dx the coefficient multiplies (0 to 4) |
| wr_data_i | input | 16 | Signed coefficient |
| valid_o | output | 1 | Result valid |
| y_o | output | 20 | Signed result, held between valid results |

## Verification
A corrupted table entry shows up only when an argument lands in that segment. The bench therefore loads every entry, sweeps arguments across many segments, and compares each result with a bench-side Horner model six edges after it was issued. A stale or misaligned coefficient vector inside the pipeline shows up as a wrong value on the first result that straddles a write, and the same-edge and next-edge write tests provoke that case. A valid flag that slips by a stage shows up at once as a latency other than six, or as a count of results that differs from the count of arguments.

// File: rtl/qseg_pkg.sv
package qseg_pkg;
  localparam int N_COEF = 5;   // quartic: c0..c4
  localparam int CIDX_W = 3;
endpackage

// File: rtl/qseg_coef_table.sv
module qseg_coef_table
  import qseg_pkg::*;
#(
  parameter int SEG_BITS = 6,
  parameter int CW       = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SEG_BITS-1:0]          wr_seg_i,
  input  logic [CIDX_W-1:0]            wr_idx_i,
  input  logic [CW-1:0]                wr_data_i,
  input  logic [SEG_BITS-1:0]          rd_seg_i,
  output logic [N_COEF-1:0][CW-1:0]    rd_coef_o
);
  localparam int NSEG = 1 << SEG_BITS;

  logic [NSEG-1:0][N_COEF-1:0][CW-1:0] mem_q;
  logic wr_ok;

  assign wr_ok = wr_en_i && (wr_idx_i < CIDX_W'(N_COEF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_ok) mem_q[wr_seg_i][wr_idx_i] <= wr_data_i;
  end

  assign rd_coef_o = mem_q[rd_seg_i];

  // R6: out-of-range coefficient index must leave the table untouched
  assert_bad_idx_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= CIDX_W'(N_COEF)) |=> $stable(mem_q));
endmodule

// File: rtl/qseg_horner_stage.sv
module qseg_horner_stage
  import qseg_pkg::*;
#(
  parameter int CW    = 16,
  parameter int AW    = 20,
  parameter int OFF_W = 10,
  parameter int K     = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       v_i,
  input  logic signed [AW-1:0]       acc_i,
  input  logic [OFF_W-1:0]           dx_i,
  input  logic [N_COEF-1:0][CW-1:0]  coef_i,
  output logic                       v_o,
  output logic signed [AW-1:0]       acc_o,
  output logic [OFF_W-1:0]           dx_o,
  output logic [N_COEF-1:0][CW-1:0]  coef_o
);
  localparam int PW = AW + OFF_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (OFF_W - 1);

  logic signed [PW-1:0] acc_x, dx_x, prod, rnd, shr;
  logic signed [AW-1:0] cext, acc_n;

  always_comb begin
    acc_x = PW'(acc_i);
    dx_x  = PW'({1'b0, dx_i});
    prod  = acc_x * dx_x;
    rnd   = prod + HALF;          // round to nearest, ties up
    shr   = rnd >>> OFF_W;
    cext  = {{(AW-CW){coef_i[K][CW-1]}}, coef_i[K]};
    acc_n = shr[AW-1:0] + cext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      acc_o  <= '0;
      dx_o   <= '0;
      coef_o <= '0;
    end else begin
      v_o    <= v_i;
      acc_o  <= acc_n;
      dx_o   <= dx_i;
      coef_o <= coef_i;
    end
  end

  // R8: zero offset passes the stage coefficient through exactly
  assert_dx_zero_exact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && dx_i == '0) |=> (acc_o == $past(cext)));
endmodule

// File: rtl/quartic_seg_eval.sv
module quartic_seg_eval
  import qseg_pkg::*;
#(
  parameter int SEG_BITS = 6,
  parameter int OFF_W    = 10,
  parameter int ARG_W    = 18,
  parameter int CW       = 16,
  parameter int AW       = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [ARG_W-1:0]      arg_i,
  input  logic                  wr_en_i,
  input  logic [SEG_BITS-1:0]   wr_seg_i,
  input  logic [CIDX_W-1:0]     wr_idx_i,
  input  logic [CW-1:0]         wr_data_i,
  output logic                  valid_o,
  output logic signed [AW-1:0]  y_o
);
  localparam int IDX_TOP = SEG_BITS + OFF_W;
  localparam int N_STG   = N_COEF - 1;
  localparam int LAT     = N_STG + 2;

  logic                 over;
  logic [SEG_BITS-1:0]  seg_sel;
  logic [OFF_W-1:0]     dx_sel;
  logic [N_COEF-1:0][CW-1:0] tbl_coef;

  if (ARG_W > IDX_TOP) begin : g_ovr
    assign over = |arg_i[ARG_W-1:IDX_TOP];
  end else begin : g_novr
    assign over = 1'b0;
  end

  assign seg_sel = over ? '1 : arg_i[OFF_W +: SEG_BITS];
  assign dx_sel  = over ? '1 : arg_i[OFF_W-1:0];

  qseg_coef_table #(.SEG_BITS(SEG_BITS), .CW(CW)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_seg_i  (wr_seg_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_seg_i  (seg_sel),
    .rd_coef_o (tbl_coef)
  );

  logic                      v_p    [N_COEF];
  logic signed [AW-1:0]      acc_p  [N_COEF];
  logic [OFF_W-1:0]          dx_p   [N_COEF];
  logic [N_COEF-1:0][CW-1:0] coef_p [N_COEF];

  // read stage: coefficients captured here, so later writes cannot reach this item
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_p[0]    <= 1'b0;
      acc_p[0]  <= '0;
      dx_p[0]   <= '0;
      coef_p[0] <= '0;
    end else begin
      v_p[0]    <= valid_i;
      acc_p[0]  <= {{(AW-CW){tbl_coef[N_COEF-1][CW-1]}}, tbl_coef[N_COEF-1]};
      dx_p[0]   <= dx_sel;
      coef_p[0] <= tbl_coef;
    end
  end

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    qseg_horner_stage #(.CW(CW), .AW(AW), .OFF_W(OFF_W), .K(N_STG-1-g)) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .v_i    (v_p[g]),
      .acc_i  (acc_p[g]),
      .dx_i   (dx_p[g]),
      .coef_i (coef_p[g]),
      .v_o    (v_p[g+1]),
      .acc_o  (acc_p[g+1]),
      .dx_o   (dx_p[g+1]),
      .coef_o (coef_p[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= v_p[N_STG];
      if (v_p[N_STG]) y_o <= acc_p[N_STG];
    end
  end

  // edges since reset, saturating; lets the latency check avoid pre-reset history
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assert_fixed_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 3'(LAT)) |-> (valid_o == $past(valid_i, LAT)));

  assert_saturate_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && over) |=> (dx_p[0] == '1));

  assert_offset_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !over) |=> (dx_p[0] == $past(arg_i[OFF_W-1:0])));

  assert_idle_out_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_p[N_STG] |=> !valid_o);
endmodule

// File: tb/sim_quartic_seg_eval.sv
module sim_quartic_seg_eval;
  localparam int SEG_BITS = 6;
  localparam int OFF_W    = 10;
  localparam int ARG_W    = 18;
  localparam int CW       = 16;
  localparam int AW       = 20;
  localparam int NSEG     = 64;
  localparam int LAT      = 6;
  localparam int NV       = 12;
  localparam logic [ARG_W-1:0] VEC [NV] = '{
    18'h00000, 18'h003FF, 18'h00400, 18'h00200, 18'h0A5A5, 18'h0C35A,
    18'h07FFF, 18'h0FC01, 18'h05555, 18'h0AAAA, 18'h00201, 18'h0E1FF
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_ni = 1'b0;
  logic                 valid_i = 1'b0;
  logic [ARG_W-1:0]     arg_i = '0;
  logic                 wr_en_i = 1'b0;
  logic [SEG_BITS-1:0]  wr_seg_i = '0;
  logic [2:0]           wr_idx_i = '0;
  logic [CW-1:0]        wr_data_i = '0;
  logic                 valid_o;
  logic signed [AW-1:0] y_o;

  quartic_seg_eval #(.SEG_BITS(SEG_BITS), .OFF_W(OFF_W), .ARG_W(ARG_W), .CW(CW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .arg_i(arg_i),
    .wr_en_i(wr_en_i), .wr_seg_i(wr_seg_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  longint shadow [NSEG][5];
  int n_chk = 0, n_bad = 0, cyc = 0, n_in = 0, n_out = 0;
  longint exp_q [128];
  int     incyc_q [128];
  string  tag_q [128];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint wrap20(longint v);
    longint t;
    t = v & 64'hFFFFF;
    if (t >= 524288) t = t - 1048576;
    return t;
  endfunction

  function automatic longint model(logic [ARG_W-1:0] a);
    int s;
    longint dx, acc, p, r;
    if (a >= 18'(NSEG << OFF_W)) begin s = NSEG - 1; dx = 1023; end
    else begin s = int'(a[OFF_W +: SEG_BITS]); dx = longint'(a[OFF_W-1:0]); end
    acc = shadow[s][4];
    for (int k = 3; k >= 0; k--) begin
      p = acc * dx;
      r = (p + 512) >>> 10;
      acc = wrap20(r + shadow[s][k]);
    end
    return acc;
  endfunction

  function automatic longint cgen(int s, int k);
    return longint'((s * 7919 + k * 104729 + 17) % 60001) - 30000;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit dv, logic [ARG_W-1:0] a, bit dw, int s, int k, longint d, string tag);
    if (dv) begin
      exp_q[n_in] = model(a);
      incyc_q[n_in] = cyc;
      tag_q[n_in] = tag;
      n_in++;
    end
    valid_i = dv; arg_i = a;
    wr_en_i = dw; wr_seg_i = s[SEG_BITS-1:0]; wr_idx_i = k[2:0]; wr_data_i = d[CW-1:0];
    if (dw && k < 5) shadow[s][k] = d;
    @(negedge clk);
    valid_i = 1'b0; wr_en_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (n_out < n_in) begin
        check(tag_q[n_out], longint'(y_o), exp_q[n_out]);
        check({tag_q[n_out], " latency R4"}, longint'(cyc - incyc_q[n_out]), LAT);
        n_out++;
      end else begin
        check("R4 result without argument", 1, 0);
      end
    end
  end

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < 5; k++) shadow[s][k] = 0;
    repeat (3) @(negedge clk);
    check("R1 valid_o in reset", longint'(valid_o), 0);
    check("R1 y_o in reset", longint'(y_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid_o after reset", longint'(valid_o), 0);
    check("R1 y_o after reset", longint'(y_o), 0);
    step(1, 18'h01234, 0, 0, 0, 0, "R1 cleared table");
    repeat (LAT + 2) @(negedge clk);

    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < 5; k++) step(0, '0, 1, s, k, cgen(s, k), "");

    // vector table, back to back
    for (int i = 0; i < NV; i++) step(1, VEC[i], 0, 0, 0, 0, "R2 R3 vector");
    repeat (LAT + 2) @(negedge clk);

    step(1, 18'(9 << OFF_W), 0, 0, 0, 0, "R8 dx zero seg 9");
    step(1, 18'(40 << OFF_W), 0, 0, 0, 0, "R8 dx zero seg 40");
    check("R8 model c0", model(18'(40 << OFF_W)), shadow[40][0]);

    step(1, 18'h0FFFF, 0, 0, 0, 0, "R5 last in-range");
    step(1, 18'h10000, 0, 0, 0, 0, "R5 limit");
    step(1, 18'h3FFFF, 0, 0, 0, 0, "R5 max arg");
    step(1, 18'h2ABCD, 0, 0, 0, 0, "R5 high bits");

    // write isolation: same edge, then following edge while in flight
    step(1, 18'((5 << OFF_W) | 300), 1, 5, 0, 12345, "R7 same-edge write");
    step(1, 18'((5 << OFF_W) | 700), 0, 0, 0, 0, "R7 sees prior write");
    step(0, '0, 1, 5, 4, -22222, "");
    step(0, '0, 1, 5, 2, 29999, "");
    step(1, 18'((5 << OFF_W) | 700), 0, 0, 0, 0, "R6 R7 new coefficients");

    // out-of-range index writes
    step(0, '0, 1, 7, 5, 32000, "");
    step(0, '0, 1, 7, 7, -32000, "");
    step(0, '0, 1, 7, 6, 1, "");
    step(1, 18'((7 << OFF_W) | 1023), 0, 0, 0, 0, "R6 ignored index top");
    step(1, 18'(7 << OFF_W), 0, 0, 0, 0, "R6 ignored index c0");

    // gaps between arguments
    step(1, 18'h03C0F, 0, 0, 0, 0, "R4 gap a");
    step(0, '0, 0, 0, 0, 0, "");
    step(0, '0, 0, 0, 0, 0, "");
    step(1, 18'h0F0F0, 0, 0, 0, 0, "R4 gap b");
    step(0, '0, 0, 0, 0, 0, "");
    step(1, 18'h06001, 0, 0, 0, 0, "R4 gap c");

    repeat (LAT + 4) @(negedge clk);
    check("R4 result count", n_out, n_in);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule